// File: doc/BRIEF.md
# Stacking Bus Request Arbiter

This block decides who may talk on a shared bus that links up to four stacked repeater units. Each unit raises a request when it has traffic for the bus. The arbiter counts the active requests: the local one plus three from the other units. It drives two active-low lines back to every unit. An acknowledge line goes low when exactly one unit is asking. A collision line goes low when two or more are asking at once. Contention is never settled by picking a winner. Every requester is told that a collision occurred.

Only one unit in a stack acts as arbiter. A master-select input gives this unit that role. An external-arbiter strap, captured while reset is held, takes the role away from the unit even when master-select is high, so that a separate arbitration device can own the lines. A unit without the role stops driving both lines and reads them from its pads instead. Whichever source is active, the block reports the acknowledge and collision states it sees. It also reports whether the local unit holds the bus, or whether it should take in data carried on the bus for it. The pad drivers, the data bus and its clock lie outside the block.

Top module: `stack_arb_top`

## Requirements
- R1: While reset is high, ack_n_o and col_n_o are 1, whatever requests are present.
- R2: With the arbiter role held, exactly one active request among local_req_i and remote_req_i[2:0] makes ack_n_o 0 and col_n_o 1 after the next rising clock edge.
- R3: With the arbiter role held, two or more active requests make col_n_o 0 and ack_n_o 1 after the next rising clock edge. ack_n_o and col_n_o are never 0 together.
- R4: With the arbiter role held and no request active, ack_n_o and col_n_o are both 1 after the next rising clock edge.
- R5: ack_oe_o and col_oe_o are 1 exactly when master_sel_i is 1 and the captured external-arbiter strap is 0.
- R6: ext_arb_i is captured only while reset is high. A change of ext_arb_i after reset has no effect on ack_oe_o or col_oe_o.
- R7: Without the arbiter role, ack_n_o and col_n_o are 1 after the next edge, and ack_seen_o and col_seen_o are the inverses of the pad inputs ack_n_i and col_n_i. With the role held, the pad inputs are ignored and the seen outputs are the inverses of ack_n_o and col_n_o.
- R8: rx_from_bus_o = !local_req_i && ack_seen_o, and tx_granted_o = local_req_i && ack_seen_o.
- R9: When requests fall from several to exactly one, the next edge returns col_n_o to 1 and ack_n_o to 0.
- R10: req_out_o equals local_req_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| master_sel_i | input | 1 | 1 selects this unit as the arbiter of the stack |
| ext_arb_i | input | 1 | Power-on strap; 1 hands the arbitration to an external device |
| local_req_i | input | 1 | Request from the local repeater core |
| remote_req_i | input | 3 | Requests from the other stacked units |
| ack_n_i | input | 1 | Acknowledge line as seen at the pad, active low |
| col_n_i | input | 1 | Collision line as seen at the pad, active low |
| req_out_o | output | 1 | Local request sent to the stack |
| ack_n_o | output | 1 | Acknowledge value to drive, active low |
| ack_oe_o | output | 1 | Drive enable for the acknowledge pad |
| col_n_o | output | 1 | Collision value to drive, active low |
| col_oe_o | output | 1 | Drive enable for the collision pad |
| ack_seen_o | output | 1 | Acknowledge in effect, active high |
| col_seen_o | output | 1 | Collision in effect, active high |
| rx_from_bus_o | output | 1 | Bus carries data for this unit to receive |
| tx_granted_o | output | 1 | This unit holds the bus alone |

## Verification
The decision is tried with every single-requester pattern: the local request alone and each remote request alone. Each must give the acknowledge, and the receive and transmit flags must split the local case from the remote ones. Pairs, triples and all four requests check that any count of two or more gives a collision, and never an acknowledge. The sequence runs from idle to contention, back to one requester, and then to idle, so that each line must release in the following cycle. Directed cases toggle master-select and the strap through and after reset. They show that the pad values, not the internal decision, feed the seen outputs only when the arbiter role is absent.

// File: rtl/stack_arb_pkg.sv
`timescale 1ns/1ps
package stack_arb_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_SINGLE  = 2'd1,
        BUS_CONTEND = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic ack_n;
        logic col_n;
    } arb_lines_t;

    localparam arb_lines_t LINES_RELEASED = '{ack_n: 1'b1, col_n: 1'b1};

    function automatic bus_state_e classify(input int unsigned n);
        if (n == 0)      return BUS_IDLE;
        else if (n == 1) return BUS_SINGLE;
        else             return BUS_CONTEND;
    endfunction

    function automatic arb_lines_t encode(input bus_state_e s);
        arb_lines_t l;
        l = LINES_RELEASED;
        case (s)
            BUS_SINGLE:  l.ack_n = 1'b0;
            BUS_CONTEND: l.col_n = 1'b0;
            default:     l = LINES_RELEASED;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/stack_arb_strap.sv
`timescale 1ns/1ps
module stack_arb_strap (
    input  logic clk,
    input  logic rst,
    input  logic master_sel_i,
    input  logic ext_arb_i,
    output logic role_o
);
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= ext_arb_i;
    end

    assign role_o = master_sel_i & ~ext_q;

    // R6: strap value frozen once reset is released
    p_strap_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ext_q));

endmodule

// File: rtl/stack_arb_decide.sv
`timescale 1ns/1ps
module stack_arb_decide
    import stack_arb_pkg::*;
#(
    parameter int N_REMOTE = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                role_i,
    input  logic                local_req_i,
    input  logic [N_REMOTE-1:0] remote_req_i,
    output arb_lines_t          lines_o
);
    localparam int N_UNITS = N_REMOTE + 1;
    localparam int CNT_W   = $clog2(N_UNITS + 1);

    logic [N_UNITS-1:0] all_req;
    logic [CNT_W-1:0]   req_cnt;
    bus_state_e         state;
    arb_lines_t         lines_q;

    assign all_req = {remote_req_i, local_req_i};

    always_comb begin
        req_cnt = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            req_cnt = req_cnt + CNT_W'(all_req[i]);
        end
    end

    assign state = classify(32'(req_cnt));

    always_ff @(posedge clk) begin
        if (rst)          lines_q <= LINES_RELEASED;
        else if (!role_i) lines_q <= LINES_RELEASED;
        else              lines_q <= encode(state);
    end

    assign lines_o = lines_q;

    p_single_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (role_i && $countones(all_req) == 1) |=> (!lines_q.ack_n && lines_q.col_n));

    p_contend_col_r3: assert property (@(posedge clk) disable iff (rst)
        (role_i && $countones(all_req) >= 2) |=> (!lines_q.col_n && lines_q.ack_n));

    p_never_both_r3: assert property (@(posedge clk) disable iff (rst)
        (lines_q.ack_n || lines_q.col_n));

    p_idle_release_r4: assert property (@(posedge clk) disable iff (rst)
        (role_i && all_req == '0) |=> (lines_q.ack_n && lines_q.col_n));

    p_passive_release_r7: assert property (@(posedge clk) disable iff (rst)
        !role_i |=> (lines_q.ack_n && lines_q.col_n));

endmodule

// File: rtl/stack_arb_view.sv
`timescale 1ns/1ps
module stack_arb_view
    import stack_arb_pkg::*;
(
    input  logic       role_i,
    input  arb_lines_t lines_i,
    input  logic       ack_n_pad_i,
    input  logic       col_n_pad_i,
    input  logic       local_req_i,
    output logic       ack_seen_o,
    output logic       col_seen_o,
    output logic       rx_from_bus_o,
    output logic       tx_granted_o
);
    arb_lines_t seen_lines;

    always_comb begin
        if (role_i) seen_lines = lines_i;
        else        seen_lines = '{ack_n: ack_n_pad_i, col_n: col_n_pad_i};
    end

    assign ack_seen_o    = ~seen_lines.ack_n;
    assign col_seen_o    = ~seen_lines.col_n;
    assign rx_from_bus_o = ~local_req_i & ack_seen_o;
    assign tx_granted_o  =  local_req_i & ack_seen_o;

endmodule

// File: rtl/stack_arb_top.sv
`timescale 1ns/1ps
module stack_arb_top
    import stack_arb_pkg::*;
#(
    parameter int N_REMOTE = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                master_sel_i,
    input  logic                ext_arb_i,
    input  logic                local_req_i,
    input  logic [N_REMOTE-1:0] remote_req_i,
    input  logic                ack_n_i,
    input  logic                col_n_i,
    output logic                req_out_o,
    output logic                ack_n_o,
    output logic                ack_oe_o,
    output logic                col_n_o,
    output logic                col_oe_o,
    output logic                ack_seen_o,
    output logic                col_seen_o,
    output logic                rx_from_bus_o,
    output logic                tx_granted_o
);
    logic       role;
    arb_lines_t lines;

    stack_arb_strap u_strap (
        .clk          (clk),
        .rst          (rst),
        .master_sel_i (master_sel_i),
        .ext_arb_i    (ext_arb_i),
        .role_o       (role)
    );

    stack_arb_decide #(.N_REMOTE(N_REMOTE)) u_decide (
        .clk          (clk),
        .rst          (rst),
        .role_i       (role),
        .local_req_i  (local_req_i),
        .remote_req_i (remote_req_i),
        .lines_o      (lines)
    );

    stack_arb_view u_view (
        .role_i        (role),
        .lines_i       (lines),
        .ack_n_pad_i   (ack_n_i),
        .col_n_pad_i   (col_n_i),
        .local_req_i   (local_req_i),
        .ack_seen_o    (ack_seen_o),
        .col_seen_o    (col_seen_o),
        .rx_from_bus_o (rx_from_bus_o),
        .tx_granted_o  (tx_granted_o)
    );

    assign req_out_o = local_req_i;
    assign ack_n_o   = lines.ack_n;
    assign col_n_o   = lines.col_n;
    assign ack_oe_o  = role;
    assign col_oe_o  = role;

endmodule

// File: tb/stack_arb_top_tb.sv
`timescale 1ns/1ps
module stack_arb_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_sel = 1'b1;
    logic       ext_arb = 1'b0;
    logic       local_req = 1'b0;
    logic [2:0] remote_req = 3'b000;
    logic       ack_n_pad = 1'b1;
    logic       col_n_pad = 1'b1;
    logic req_out, ack_n, ack_oe, col_n, col_oe, ack_seen, col_seen, rx_bus, tx_gr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stack_arb_top #(.N_REMOTE(3)) u_dut (
        .clk(clk), .rst(rst), .master_sel_i(master_sel), .ext_arb_i(ext_arb),
        .local_req_i(local_req), .remote_req_i(remote_req),
        .ack_n_i(ack_n_pad), .col_n_i(col_n_pad),
        .req_out_o(req_out), .ack_n_o(ack_n), .ack_oe_o(ack_oe),
        .col_n_o(col_n), .col_oe_o(col_oe), .ack_seen_o(ack_seen),
        .col_seen_o(col_seen), .rx_from_bus_o(rx_bus), .tx_granted_o(tx_gr)
    );

    // {local, remote[2:0], expected ack_n, expected col_n}
    localparam logic [5:0] VEC [12] = '{
        6'b0_000_11, 6'b1_000_01, 6'b0_001_01, 6'b0_010_01,
        6'b0_100_01, 6'b1_001_10, 6'b0_011_10, 6'b0_111_10,
        6'b1_111_10, 6'b0_100_01, 6'b1_110_10, 6'b0_000_11
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1;
        ext_arb = strap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: requests active during reset keep both lines released
        local_req = 1'b1;
        remote_req = 3'b111;
        repeat (3) @(negedge clk);
        chk("R1 lines in reset", {2'b00, ack_n, col_n}, 4'b0011);
        local_req = 1'b0;
        remote_req = 3'b000;
        rst = 1'b0;
        @(negedge clk);
        // R5: master with strap low drives both lines
        chk("R5 enables as master", {2'b00, ack_oe, col_oe}, 4'b0011);

        // R2 R3 R4 R8 R9 R10: vector walk
        for (int i = 0; i < 12; i++) begin
            local_req  = VEC[i][5];
            remote_req = VEC[i][4:2];
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R9 vec %0d lines", i), {2'b00, ack_n, col_n},
                {2'b00, VEC[i][1:0]});
            chk($sformatf("R7 seen vec %0d", i), {2'b00, ack_seen, col_seen},
                {2'b00, ~VEC[i][1], ~VEC[i][0]});
            chk($sformatf("R8 rx/tx vec %0d", i), {2'b00, rx_bus, tx_gr},
                {2'b00, ~VEC[i][5] & ~VEC[i][1], VEC[i][5] & ~VEC[i][1]});
            chk($sformatf("R10 req_out vec %0d", i), {3'b000, req_out}, {3'b000, VEC[i][5]});
        end

        // R7: pad values ignored while holding the role
        ack_n_pad = 1'b0;
        col_n_pad = 1'b0;
        local_req = 1'b0;
        remote_req = 3'b000;
        @(negedge clk);
        chk("R7 pads ignored as master", {2'b00, ack_seen, col_seen}, 4'b0000);

        // R7: remote master, internal lines released and pads observed
        master_sel = 1'b0;
        local_req = 1'b1;
        remote_req = 3'b011;
        ack_n_pad = 1'b1;
        col_n_pad = 1'b0;
        @(negedge clk);
        chk("R5 enables off as slave", {2'b00, ack_oe, col_oe}, 4'b0000);
        chk("R7 released as slave", {2'b00, ack_n, col_n}, 4'b0011);
        chk("R7 pad collision seen", {2'b00, ack_seen, col_seen}, 4'b0001);
        local_req = 1'b0;
        remote_req = 3'b000;
        ack_n_pad = 1'b0;
        col_n_pad = 1'b1;
        @(negedge clk);
        chk("R8 receive from pad ack", {2'b00, rx_bus, tx_gr}, 4'b0010);
        local_req = 1'b1;
        @(negedge clk);
        chk("R8 grant from pad ack", {2'b00, rx_bus, tx_gr}, 4'b0001);
        ack_n_pad = 1'b1;

        // R5 R6: strap high through reset removes the role; later drop ignored
        master_sel = 1'b1;
        local_req = 1'b1;
        remote_req = 3'b000;
        do_reset(1'b1);
        @(negedge clk);
        ext_arb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 strap drop after reset ignored", {2'b00, ack_oe, col_oe}, 4'b0000);
        chk("R7 external arbiter leaves lines released", {2'b00, ack_n, col_n}, 4'b0011);

        // R6: strap low through reset, later rise ignored
        do_reset(1'b0);
        @(negedge clk);
        ext_arb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 strap rise after reset ignored", {2'b00, ack_oe, col_oe}, 4'b0011);
        chk("R2 single local request after re-reset", {2'b00, ack_n, col_n}, 4'b0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule